// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the running precision time of a network controller as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock it adds a programmable step to the nanoseconds. The step has a whole-nanosecond part and a 24-bit sub-nanosecond fraction. The fraction builds up in an accumulator, and each time that accumulator overflows, one extra nanosecond is added. When the nanoseconds reach one billion, they wrap and the seconds count goes up by one.

Software reaches the block through a single-cycle register write port and a combinational read port. Software can load the time, retune the step and nudge the time by a signed nanosecond amount. Two writes are deferred on purpose. A new fraction waits until the whole-nanosecond step is written. The upper seconds wait until the lower seconds are written. This lets software change a multi-word value as one update.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the seconds, nanoseconds, fraction accumulator, active step and staged values are all zero, so the counter does not advance.
- R2: On each clock without a time-load write, nanoseconds advance by the active whole-ns step. One more nanosecond is added in a cycle where adding the active fraction to the 24-bit accumulator carries out.
- R3: A write to address 3 stages a 24-bit fraction. Fraction bits [23:8] come from data bits [15:0], and fraction bits [7:0] come from data bits [31:24].
- R4: The staged fraction becomes active only when address 4 is written. That write also sets the 8-bit whole-ns step from data bits [7:0]. The new step applies from the next cycle on.
- R5: When nanoseconds would reach 1,000,000,000 or more, 1,000,000,000 is subtracted and seconds increase by one, with the carry going across all 48 bits.
- R6: A write to address 1 holds data bits [15:0] without changing the time. A write to address 0 loads all 48 seconds bits at once: the held value on top and the data below. The counter does not tick in that cycle.
- R7: A write to address 2 loads nanoseconds from data bits [29:0]. Seconds and the accumulator hold in that cycle.
- R8: A write to address 5 adjusts the time once. Bits [29:0] give a magnitude below one second. Bit 31 set means subtract and bit 31 clear means add. A subtraction below zero borrows one second.
- R9: An adjust and the normal tick in the same cycle are both applied in that cycle, with one wrap or borrow.
- R10: With both step fields zero and no writes, the seconds and nanoseconds stay unchanged.
- R11: The read port returns, by address: 0 the seconds bits [31:0]; 1 the seconds bits [47:32] in bits [15:0]; 2 the nanoseconds; 3 the active fraction in bits [23:0]; 4 the active whole-ns step in bits [7:0]. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 32 | Read data (combinational) |

## Verification
The bench builds the block with its default widths: 48-bit seconds, 30-bit nanoseconds, a 24-bit fraction and an 8-bit step, with a one-billion wrap. At these sizes, loading nanoseconds just below the wrap point and the low seconds to all ones reaches both the nanosecond wrap and the 32-to-48-bit seconds carry within a few cycles. Random steps, fractions and signed adjusts near zero and near the wrap point reach the borrow path and the combined adjust-plus-tick path.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADJ_SIGN = 31;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC_LO  = 3'd0,
    A_SEC_HI  = 3'd1,
    A_NSEC    = 3'd2,
    A_SUB_INC = 3'd3,
    A_NS_INC  = 3'd4,
    A_ADJ     = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ptp_incr_regs.sv
`timescale 1ns/1ps
module ptp_incr_regs #(
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned NSINC_W = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned STEP_W = NSINC_W + 1,
  localparam int unsigned HI_W   = FRAC_W - 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sub_wr_i,
  input  logic               ns_inc_wr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               adv_i,
  output logic [STEP_W-1:0]  step_o,
  output logic [FRAC_W-1:0]  frac_act_o,
  output logic [NSINC_W-1:0] ns_inc_act_o
);
  logic [FRAC_W-1:0] frac_stage_q, frac_act_q, frac_acc_q;
  logic [NSINC_W-1:0] ns_inc_q;
  logic [FRAC_W:0] frac_sum;

  assign frac_sum     = {1'b0, frac_acc_q} + {1'b0, frac_act_q};
  assign step_o       = {1'b0, ns_inc_q} + STEP_W'(frac_sum[FRAC_W]);
  assign frac_act_o   = frac_act_q;
  assign ns_inc_act_o = ns_inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_stage_q <= '0;
      frac_act_q   <= '0;
      frac_acc_q   <= '0;
      ns_inc_q     <= '0;
    end else begin
      // fraction split across the word: upper part low, lower byte on top
      if (sub_wr_i) frac_stage_q <= {data_i[HI_W-1:0], data_i[DATA_W-1:DATA_W-8]};
      if (ns_inc_wr_i) begin
        ns_inc_q   <= data_i[NSINC_W-1:0];
        frac_act_q <= frac_stage_q;
      end
      if (adv_i) frac_acc_q <= frac_sum[FRAC_W-1:0];
    end
  end

  a_r4_stage_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ns_inc_wr_i |=> ($stable(frac_act_o) && $stable(ns_inc_act_o)));
  a_r4_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_inc_wr_i |=> (ns_inc_act_o == $past(data_i[NSINC_W-1:0])));
endmodule

// File: rtl/ptp_time_core.sv
`timescale 1ns/1ps
module ptp_time_core #(
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned STEP_W     = 9,
  parameter int unsigned NS_PER_SEC = 1000000000,
  localparam int unsigned SUM_W     = NS_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              adj_i,
  input  logic              adj_neg_i,
  input  logic [NS_W-1:0]   adj_mag_i,
  input  logic              sec_load_i,
  input  logic [SEC_W-1:0]  sec_load_val_i,
  input  logic              ns_load_i,
  input  logic [NS_W-1:0]   ns_load_val_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam logic signed [SUM_W-1:0] ROLL = SUM_W'(NS_PER_SEC);

  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [NS_W-1:0]  ns_q, ns_nxt;
  logic signed [SUM_W-1:0] base, adj_term, sum;

  always_comb begin
    base     = $signed({{(SUM_W-NS_W){1'b0}}, ns_q}) + $signed({{(SUM_W-STEP_W){1'b0}}, step_i});
    adj_term = adj_i ? $signed({{(SUM_W-NS_W){1'b0}}, adj_mag_i}) : '0;
    sum      = adj_neg_i ? (base - adj_term) : (base + adj_term);
    sec_nxt  = sec_q;
    ns_nxt   = ns_q;
    if (adv_i) begin
      if (sum >= ROLL) begin
        ns_nxt  = NS_W'(sum - ROLL);
        sec_nxt = sec_q + SEC_W'(1);
      end else if (sum < 0) begin
        ns_nxt  = NS_W'(sum + ROLL);
        sec_nxt = sec_q - SEC_W'(1);
      end else begin
        ns_nxt  = NS_W'(sum);
      end
    end
    if (ns_load_i)  ns_nxt  = ns_load_val_i;
    if (sec_load_i) sec_nxt = sec_load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_nxt;
      ns_q  <= ns_nxt;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  a_r5_ns_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ns_load_i |=> (ns_o < NS_W'(NS_PER_SEC)));
  a_r5_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_load_i |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + SEC_W'(1)
                     || sec_o == $past(sec_o) - SEC_W'(1)));
  a_r7_ns_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_load_i |=> (ns_o == $past(ns_load_val_i)));
  a_r10_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && step_i == '0 && !adj_i) |=> ($stable(ns_o) && $stable(sec_o)));
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned FRAC_W     = 24,
  parameter int unsigned NSINC_W    = 8,
  parameter int unsigned NS_PER_SEC = 1000000000,
  localparam int unsigned SECHI_W   = SEC_W - DATA_W,
  localparam int unsigned STEP_W    = NSINC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic wr_sec_lo, wr_sec_hi, wr_nsec, wr_sub, wr_nsinc, wr_adj, adv;
  logic [SECHI_W-1:0] sec_hi_q;
  logic [STEP_W-1:0]  step;
  logic [FRAC_W-1:0]  frac_act;
  logic [NSINC_W-1:0] ns_inc_act;
  logic [SEC_W-1:0]   sec;
  logic [NS_W-1:0]    ns;

  assign wr_sec_lo = wr_en_i && wr_addr_i == A_SEC_LO;
  assign wr_sec_hi = wr_en_i && wr_addr_i == A_SEC_HI;
  assign wr_nsec   = wr_en_i && wr_addr_i == A_NSEC;
  assign wr_sub    = wr_en_i && wr_addr_i == A_SUB_INC;
  assign wr_nsinc  = wr_en_i && wr_addr_i == A_NS_INC;
  assign wr_adj    = wr_en_i && wr_addr_i == A_ADJ;
  assign adv       = !(wr_sec_lo || wr_nsec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_hi_q <= '0;
    else if (wr_sec_hi) sec_hi_q <= wr_data_i[SECHI_W-1:0];
  end

  ptp_incr_regs #(.FRAC_W(FRAC_W), .NSINC_W(NSINC_W), .DATA_W(DATA_W)) u_incr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_wr_i    (wr_sub),
    .ns_inc_wr_i (wr_nsinc),
    .data_i      (wr_data_i),
    .adv_i       (adv),
    .step_o      (step),
    .frac_act_o  (frac_act),
    .ns_inc_act_o(ns_inc_act)
  );

  ptp_time_core #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .NS_PER_SEC(NS_PER_SEC)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .adv_i         (adv),
    .step_i        (step),
    .adj_i         (wr_adj),
    .adj_neg_i     (wr_data_i[ADJ_SIGN]),
    .adj_mag_i     (wr_data_i[NS_W-1:0]),
    .sec_load_i    (wr_sec_lo),
    .sec_load_val_i({sec_hi_q, wr_data_i}),
    .ns_load_i     (wr_nsec),
    .ns_load_val_i (wr_data_i[NS_W-1:0]),
    .sec_o         (sec),
    .ns_o          (ns)
  );

  always_comb begin
    unique case (rd_addr_i)
      A_SEC_LO:  rd_data_o = sec[DATA_W-1:0];
      A_SEC_HI:  rd_data_o = DATA_W'(sec[SEC_W-1:DATA_W]);
      A_NSEC:    rd_data_o = DATA_W'(ns);
      A_SUB_INC: rd_data_o = DATA_W'(frac_act);
      A_NS_INC:  rd_data_o = DATA_W'(ns_inc_act);
      default:   rd_data_o = '0;
    endcase
  end

  a_r6_sec_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec_lo |=> (sec == {$past(sec_hi_q), $past(wr_data_i)}));
  a_r6_hi_defer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec_hi |=> (sec[SEC_W-1:DATA_W] == $past(sec[SEC_W-1:DATA_W])
                   || sec[SEC_W-1:DATA_W] == $past(sec[SEC_W-1:DATA_W]) + SECHI_W'(1)));
  a_r11_unused_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i > ADDR_W'(A_ADJ)) |-> (rd_data_o == '0));
endmodule

// File: tb/ptp_tod_counter_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_counter_tb_top;
  localparam longint ROLL = 1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;

  longint m_sec, m_ns, m_frac, m_sub, m_inc, m_stage, m_hi;

  always #2.5 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic void model_cycle(input logic we, input logic [2:0] a, input logic [31:0] d);
    longint fs, t;
    if (we && a == 3'd0) m_sec = (m_hi << 32) | longint'(d);
    else if (we && a == 3'd2) m_ns = longint'(d[29:0]);
    else begin
      fs     = m_frac + m_sub;
      m_frac = fs & 64'hFF_FFFF;
      t      = m_ns + m_inc + (fs >> 24);
      if (we && a == 3'd5) t = d[31] ? t - longint'(d[29:0]) : t + longint'(d[29:0]);
      if (t >= ROLL) begin t = t - ROLL; m_sec = m_sec + 1; end
      else if (t < 0) begin t = t + ROLL; m_sec = m_sec - 1; end
      m_ns  = t;
      m_sec = m_sec & 64'hFFFF_FFFF_FFFF;
    end
    if (we && a == 3'd1) m_hi = longint'(d[15:0]);
    if (we && a == 3'd3) m_stage = (longint'(d[15:0]) << 8) | longint'(d[31:24]);
    if (we && a == 3'd4) begin m_inc = longint'(d[7:0]); m_sub = m_stage; end
  endfunction

  task automatic check_rd(input logic [2:0] a, input longint exp, input string tag);
    rd_addr = a;
    #0.3;
    checks++;
    if (rd_data !== 32'(exp)) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, 32'(exp));
    end
  endtask

  task automatic check_time(input string tag);
    check_rd(3'd0, m_sec & 64'hFFFF_FFFF, tag);
    check_rd(3'd1, m_sec >> 32, tag);
    check_rd(3'd2, m_ns, tag);
  endtask

  task automatic op(input logic we, input logic [2:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_cycle(we, a, d);
    #0.2;
    check_time(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) op(1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1588));
    m_sec = 0; m_ns = 0; m_frac = 0; m_sub = 0; m_inc = 0; m_stage = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and read map
    #0.2;
    check_time("R1");
    check_rd(3'd3, 0, "R1");
    check_rd(3'd4, 0, "R1");
    idle(4, "R1 R10");
    // R3/R4: staged fraction, bit reorder, commit
    op(1'b1, 3'd3, 32'hCD00_AB12, "R4");
    check_rd(3'd3, 0, "R4 staged not active");
    idle(2, "R4");
    op(1'b1, 3'd4, 32'h0000_0008, "R4");
    check_rd(3'd3, 64'hAB12CD, "R3");
    check_rd(3'd4, 8, "R4");
    // R11: unused addresses
    check_rd(3'd5, 0, "R11");
    check_rd(3'd7, 0, "R11");
    // R7 then R2 ticking with fraction carry
    op(1'b1, 3'd2, 32'd100, "R7");
    idle(40, "R2");
    // R5 nanosecond wrap
    op(1'b1, 3'd2, 32'd999_999_990, "R7");
    idle(4, "R5");
    // R6 deferred high seconds and 48-bit load
    op(1'b1, 3'd1, 32'h0000_1234, "R6");
    idle(2, "R6 hi held");
    op(1'b1, 3'd0, 32'hFFFF_FFFF, "R6");
    op(1'b1, 3'd2, 32'd999_999_995, "R7");
    idle(3, "R5 carry into high seconds");
    // R8 subtract with borrow, R9 combined with tick
    op(1'b1, 3'd2, 32'd5, "R7");
    op(1'b1, 3'd5, 32'h8000_0064, "R8 borrow");
    op(1'b1, 3'd5, 32'd999_999_000, "R9 add wrap");
    op(1'b1, 3'd5, 32'h8000_0001, "R9 sub");
    idle(2, "R8");
    // R10 zero increment
    op(1'b1, 3'd3, 32'h0, "R10");
    op(1'b1, 3'd4, 32'h0, "R10");
    idle(6, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 19);
      logic [31:0] d = $urandom;
      if (sel < 12) op(1'b0, 3'd0, 32'd0, "R2 R5 random");
      else if (sel == 12) op(1'b1, 3'd0, d, "R6 random");
      else if (sel == 13) op(1'b1, 3'd1, d, "R6 random");
      else if (sel == 14) op(1'b1, 3'd2, ($urandom_range(0, 1) != 0) ? 32'(ROLL - 1 - $urandom_range(0, 600)) : 32'(d % 32'd1000000000), "R7 random");
      else if (sel == 15) op(1'b1, 3'd3, d, "R3 random");
      else if (sel == 16) op(1'b1, 3'd4, d, "R4 random");
      else begin
        logic [31:0] mag = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 2000)) : 32'(d % 32'd1000000000);
        op(1'b1, 3'd5, {d[31], 1'b0, mag[29:0]}, "R8 R9 random");
      end
      if (i % 50 == 0) begin
        check_rd(3'd3, m_sub, "R3 R11 random");
        check_rd(3'd4, m_inc, "R4 R11 random");
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule